// File: doc/BRIEF.md
# ADC Window Alert Monitor

This block compares each new 8-bit conversion sample against a programmable lower bound and a programmable upper bound, and keeps a separate flag for each side. A sample above the upper bound raises the over-range flag. A sample below the lower bound raises the under-range flag.

Each flag can be set to clear itself once the samples return far enough inside the window, with a hysteresis margin. It can instead be held until software clears it with a write-one-to-clear to the status register.

The alert state is driven onto an output pin. The pin's polarity can be chosen, and it has a separate output-enable for tri-state use. The alert state can also be placed in the top bit of the 16-bit result word. A small register port holds the configuration, both bounds and the hysteresis, and reads them back combinationally. Register pointers: 0 result word, 1 status (bit 1 over-range flag, bit 0 under-range flag), 2 configuration, 3 lower bound, 4 upper bound, 5 hysteresis.

Top module: `adc_window_alert`

## Requirements
- R1: After reset, the lower bound, hysteresis, configuration and status read 0000h, and the upper bound reads 0FF0h (field FFh).
- R2: The lower bound, upper bound and hysteresis each hold their 8-bit value in bits 11:4. All other bits read zero, and writes to them have no effect.
- R3: A valid sample strictly greater than the upper bound sets the over-range flag, visible one cycle later. A sample equal to the bound does not set it.
- R4: A valid sample strictly less than the lower bound sets the under-range flag, visible one cycle later. A sample equal to the bound does not set it.
- R5: With hold (configuration bit 4) at 0, the over-range flag clears on a sample below (upper bound − hysteresis), and the under-range flag clears on a sample above (lower bound + hysteresis). A sample exactly at either threshold keeps the flag. When no sample arrives and no status write happens, both flags keep their value.
- R6: With hold at 1, samples never clear a flag. Writing 1 to status bit 1 clears the over-range flag, and writing 1 to status bit 0 clears the under-range flag. A written 0 has no effect.
- R7: If a sample that sets a flag arrives in the same cycle as a write that clears that flag, the flag ends up set.
- R8: The result word carries the last valid sample in bits 11:4. Bit 15 equals (over OR under) when configuration bit 3 is 1, and is 0 otherwise. All other bits are zero.
- R9: The alert pin's output enable follows configuration bit 2.
- R10: The alert pin equals (over OR under) when configuration bit 0 is 1, and its inverse when bit 0 is 0.
- R11: Configuration bits 7:5 are stored and appear on the cycle-code output. Configuration bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New sample strobe |
| smp_data | input | 8 | Sample value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register pointer |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data at reg_addr |
| result_word | output | 16 | Last sample with optional alert bit |
| alert_out | output | 1 | Alert pin level after polarity |
| alert_oe | output | 1 | Alert pin output enable |
| cycle_code | output | 3 | Stored cycle-time code |

## Verification
A sample or register write presented before a rising edge shows up in the flags, the result word, the pin and the read data just after that edge, so every result is due one cycle after its stimulus. The bench drives inputs one nanosecond after an edge and compares the outputs against its model just after the following edge. For registers read back, it sets the pointer and reads one nanosecond later, well before the next edge.

// File: rtl/adc_window_alert.sv
module adc_window_alert #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W+7:0] reg_wdata,
  output logic [DATA_W+7:0] reg_rdata,
  output logic [DATA_W+7:0] result_word,
  output logic              alert_out,
  output logic              alert_oe,
  output logic [2:0]        cycle_code
);
  localparam int RW = DATA_W + 8;
  localparam int FH = DATA_W + 3;
  localparam logic [ADDR_W-1:0] A_RES = 0, A_STAT = 1, A_CFG = 2,
                                A_LO = 3, A_HI = 4, A_HYS = 5;

  logic [DATA_W-1:0] lo_lim, hi_lim, hyst, res;
  logic [2:0] cyc;
  logic hold, flag_en, pin_en, pol, hi_f, lo_f;

  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire [DATA_W:0] d_ext = {1'b0, smp_data};
  wire hi_set  = smp_valid && smp_data > hi_lim;
  wire lo_set  = smp_valid && smp_data < lo_lim;
  wire hi_heal = smp_valid && !hold && (d_ext + {1'b0, hyst} < {1'b0, hi_lim});
  wire lo_heal = smp_valid && !hold && (d_ext > {1'b0, lo_lim} + {1'b0, hyst});
  wire active  = hi_f | lo_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo_lim <= '0; hi_lim <= '1; hyst <= '0; res <= '0;
      {cyc, hold, flag_en, pin_en, pol} <= '0;
    end else begin
      if (smp_valid) res <= smp_data;
      if (reg_we)
        case (reg_addr)
          A_CFG: {cyc, hold, flag_en, pin_en, pol} <=
                 {reg_wdata[7:2], reg_wdata[0]};
          A_LO:  lo_lim <= reg_wdata[FH:4];
          A_HI:  hi_lim <= reg_wdata[FH:4];
          A_HYS: hyst   <= reg_wdata[FH:4];
          default: ;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_f <= 1'b0; lo_f <= 1'b0;
    end else begin
      if (hi_set) hi_f <= 1'b1;
      else if (hi_heal || (wr_stat && reg_wdata[1])) hi_f <= 1'b0;
      if (lo_set) lo_f <= 1'b1;
      else if (lo_heal || (wr_stat && reg_wdata[0])) lo_f <= 1'b0;
    end

  always_comb begin
    result_word = '0;
    result_word[FH:4] = res;
    result_word[RW-1] = flag_en & active;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RES:  reg_rdata = result_word;
      A_STAT: reg_rdata[1:0] = {hi_f, lo_f};
      A_CFG:  reg_rdata[7:0] = {cyc, hold, flag_en, pin_en, 1'b0, pol};
      A_LO:   reg_rdata[FH:4] = lo_lim;
      A_HI:   reg_rdata[FH:4] = hi_lim;
      A_HYS:  reg_rdata[FH:4] = hyst;
      default: ;
    endcase
  end

  assign alert_out  = pol ? active : ~active;
  assign alert_oe   = pin_en;
  assign cycle_code = cyc;

  assert_over_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_data > hi_lim |=> hi_f);
  assert_under_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_data < lo_lim |=> lo_f);
  assert_quiet_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !wr_stat |=> $stable({hi_f, lo_f}));
  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold && hi_f && !(wr_stat && reg_wdata[1]) |=> hi_f);
  assert_hold_keeps_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold && lo_f && !(wr_stat && reg_wdata[0]) |=> lo_f);
endmodule

// File: tb/adc_window_alert_bench.sv
`timescale 1ns/1ps
module adc_window_alert_bench;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, reg_we = 0;
  logic [7:0] smp_data = 0;
  logic [2:0] reg_addr = 1;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata, result_word;
  logic alert_out, alert_oe;
  logic [2:0] cycle_code;
  int checks = 0, errors = 0;

  logic [7:0] m_lo = 0, m_hi = 8'hff, m_hys = 0, m_res = 0, m_cfg = 0;
  logic m_hf = 0, m_lf = 0;

  always #2 clk = ~clk;

  adc_window_alert u_adc_window_alert (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    w[11:4] = m_res;
    w[15] = m_cfg[3] & (m_hf | m_lf);
    return w;
  endfunction

  function automatic logic exp_pin();
    return m_cfg[0] ? (m_hf | m_lf) : ~(m_hf | m_lf);
  endfunction

  task automatic step(string tag, bit v, logic [7:0] d, bit we,
                      logic [2:0] a, logic [15:0] wd);
    logic nh, nl;
    bit stat_w;
    smp_valid = v; smp_data = d; reg_we = we; reg_addr = a; reg_wdata = wd;
    stat_w = we && a == 3'd1;
    nh = m_hf; nl = m_lf;
    if (v && d > m_hi) nh = 1;
    else if ((v && !m_cfg[4] && ({1'b0, d} + {1'b0, m_hys} < {1'b0, m_hi})) ||
             (stat_w && wd[1])) nh = 0;
    if (v && d < m_lo) nl = 1;
    else if ((v && !m_cfg[4] && ({1'b0, d} > {1'b0, m_lo} + {1'b0, m_hys})) ||
             (stat_w && wd[0])) nl = 0;
    @(posedge clk);
    m_hf = nh; m_lf = nl;
    if (v) m_res = d;
    if (we)
      case (a)
        3'd2: m_cfg = wd[7:0] & 8'hfd;
        3'd3: m_lo = wd[11:4];
        3'd4: m_hi = wd[11:4];
        3'd5: m_hys = wd[11:4];
        default: ;
      endcase
    #1;
    smp_valid = 0; reg_we = 0; reg_addr = 3'd1;
    #1;
    chk({tag, " word"}, result_word, exp_word());
    chk({tag, " status"}, reg_rdata, {14'd0, m_hf, m_lf});
    chk({tag, " pin"}, {15'd0, alert_out}, {15'd0, exp_pin()});
    chk({tag, " oe"}, {15'd0, alert_oe}, {15'd0, m_cfg[2]});
    chk({tag, " code"}, {13'd0, cycle_code}, {13'd0, m_cfg[7:5]});
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    #9 rst_n = 1;
    @(posedge clk); #1;
    rd("R1 low", 3'd3, 16'h0000);
    rd("R1 high", 3'd4, 16'h0ff0);
    rd("R1 hyst", 3'd5, 16'h0000);
    rd("R1 cfg", 3'd2, 16'h0000);
    rd("R1 status", 3'd1, 16'h0000);
    @(posedge clk); #1;
    step("R2 high write", 0, 0, 1, 3'd4, 16'hfc0f);
    rd("R2 high field", 3'd4, 16'h0c00);
    step("R2 low write", 0, 0, 1, 3'd3, 16'hf40a);
    rd("R2 low field", 3'd3, 16'h0400);
    step("R2 hyst write", 0, 0, 1, 3'd5, 16'h7105);
    rd("R2 hyst field", 3'd5, 16'h0100);
    step("R11 cfg write", 0, 0, 1, 3'd2, 16'h00ef);
    rd("R11 cfg bit1 zero", 3'd2, 16'h00ed);
    step("R11 cfg", 0, 0, 1, 3'd2, 16'h002d);
    step("R3 equal", 1, 8'hc0, 0, 0, 0);
    step("R3 above", 1, 8'hc1, 0, 0, 0);
    chk("R8 alert bit", result_word, 16'h8c10);
    chk("R10 active high", {15'd0, alert_out}, 16'd1);
    step("R5 at threshold", 1, 8'hb0, 0, 0, 0);
    step("R5 below threshold", 1, 8'haf, 0, 0, 0);
    step("R4 equal", 1, 8'h40, 0, 0, 0);
    step("R4 below", 1, 8'h3f, 0, 0, 0);
    step("R5 low at threshold", 1, 8'h50, 0, 0, 0);
    step("R5 low above", 1, 8'h51, 0, 0, 0);
    step("R6 hold on", 0, 0, 1, 3'd2, 16'h001d);
    step("R6 set hi", 1, 8'hff, 0, 0, 0);
    step("R6 set lo", 1, 8'h00, 0, 0, 0);
    step("R6 mid sample", 1, 8'h80, 0, 0, 0);
    step("R6 write zero", 0, 0, 1, 3'd1, 16'h0000);
    step("R6 clear hi", 0, 0, 1, 3'd1, 16'h0002);
    chk("R6 lo kept", reg_rdata, 16'h0001);
    step("R7 set wins", 1, 8'hff, 1, 3'd1, 16'h0003);
    chk("R7 hi set", reg_rdata, 16'h0002);
    step("R9 pin off low pol", 0, 0, 1, 3'd2, 16'h0010);
    chk("R10 active low", {15'd0, alert_out}, 16'd0);
    chk("R9 oe off", {15'd0, alert_oe}, 16'd0);
    chk("R8 bit off", result_word, 16'h0ff0);
    for (int i = 0; i < 1500; i++) begin
      bit v, we;
      logic [7:0] d;
      logic [2:0] a;
      logic [15:0] wd;
      v = ($urandom % 3) != 0;
      d = ($urandom % 2) ? (($urandom % 2) ? m_hi : m_lo) + 8'($urandom % 5) - 8'd2
                         : 8'($urandom);
      we = ($urandom % 4) == 0;
      a = 3'd1 + 3'($urandom % 5);
      wd = 16'($urandom);
      if (a == 3'd5) wd[11:8] = 4'd0;
      step("R3 R4 R5 R6 R7 R8 R9 R10 R11 random", v, d, we, a, wd);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule